// File: doc/BRIEF.md
# GPIO Port Output Register Unit

This block is the register side of a 16-pin general-purpose I/O port. A simple synchronous register bus writes and reads a set of per-pin control words: direction, output data, a data mask, pulse enable and pulse base level, two output delay selects, an open-drain select and a readback enable. The output data can be written directly through the mask, or changed bit by bit through write-one set, clear and toggle words. A combined set/clear word lets software raise some pins and drop others in one write.

Each pin drives an output-enable and an output value towards its pad. A pin in pulse mode rests at its base level and shows the opposite level for exactly one clock after each output event. The value can pass through zero to three registered delay stages. Pad inputs arrive already synchronized and are returned through a raw read word and a masked read word.

Every control is one bit at the position of the pin number in a 32-bit word. Reads are combinational from the address. Writes take effect at the clock edge that samples them.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, direction, output data, pulse enable, pulse base, both delay selects, open-drain and readback enable all read 0. The data mask reads 0x0000FFFF, and pad_oe and pad_out are all 0.
- R2: Word address 1 (set), 2 (clear) and 3 (toggle) are write-one. A 1 in bit i forces, drops or inverts the output data of pin i at the sampling edge. A 0 bit leaves the pin unchanged. These words ignore the data mask, and reading the output data at address 0 shows the result.
- R3: Word address 4 carries set bits in [15:0] and clear bits in [31:16]. When a pin has both bits at 1, set wins and the pin ends at 1.
- R4: With pulse, delay and open-drain off, pad_oe[i] equals the direction bit (address 5, 1 = output) and pad_out[i] equals the output data bit after the write edge.
- R5: A write to address 0 updates the output data only for pins whose mask bit (address 6) is 1. Masked-off pins keep their value.
- R6: Address 7 returns the raw input levels whatever the mask. Address 8 returns those levels ANDed with the mask.
- R7: An input pin (direction 0) is always visible on the read words. An output pin reads 0 there unless its readback-enable bit (address 14) is 1.
- R8: With pulse enable (address 9) set, any write with a 1 for that pin at address 1, 2, 3 or 4 drives pad_out to the inverse of the pulse base (address 10) for exactly one clock, after which it returns to the base.
- R9: Delay select 1 (address 11) alone delays pad_out by 1 cycle, delay select 2 (address 12) alone by 2 cycles, and both together by 3 cycles.
- R10: With open-drain (address 13) set on an output pin, output value 0 gives pad_oe=1 with pad_out=0, and value 1 gives pad_oe=0. pad_out is always 0 on such a pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Synchronized pad input levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |

## Verification
A register write is sampled at one rising edge. The written state, and any undelayed pad output, is valid from that edge onward. A pulse lasts exactly until the following edge, and each delay stage adds one more edge. The bench drives inputs on falling edges and checks at the falling edge right after the capturing edge. For the pulse and delay cases it then advances one falling edge at a time and checks each pin at the exact edge count its delay or pulse calls for. Reads are combinational, so a read is sampled a short time after the address settles, with no clock edge in between.

// File: rtl/gpio_port_pkg.sv
// Package: word addresses of the GPIO port register unit.
// Assumes a 4-bit word address; unlisted addresses read as zero.
package gpio_port_pkg;
    localparam int GP_AW = 4;
    typedef logic [GP_AW-1:0] gp_addr_t;

    localparam gp_addr_t GP_DOUT   = 4'd0;   // masked output data write / output data read
    localparam gp_addr_t GP_SET    = 4'd1;   // write-one set
    localparam gp_addr_t GP_CLR    = 4'd2;   // write-one clear
    localparam gp_addr_t GP_TGL    = 4'd3;   // write-one toggle
    localparam gp_addr_t GP_SETCLR = 4'd4;   // set in low half, clear in high half
    localparam gp_addr_t GP_DIR    = 4'd5;
    localparam gp_addr_t GP_MASK   = 4'd6;
    localparam gp_addr_t GP_RAWIN  = 4'd7;
    localparam gp_addr_t GP_MSKIN  = 4'd8;
    localparam gp_addr_t GP_PEN    = 4'd9;
    localparam gp_addr_t GP_PBASE  = 4'd10;
    localparam gp_addr_t GP_DLY1   = 4'd11;
    localparam gp_addr_t GP_DLY2   = 4'd12;
    localparam gp_addr_t GP_ODRN   = 4'd13;
    localparam gp_addr_t GP_RBEN   = 4'd14;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds the per-pin control words and the output data register.
// Decodes bus writes and applies set > clear > toggle > masked-write priority
// per bit. Also reports which pins saw an output event this cycle.
// Assumes NPINS <= DW/2 so the combined set/clear word fits.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  gp_addr_t         addr,
    input  logic [DW-1:0]    wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] pen_q,
    output logic [NPINS-1:0] pbase_q,
    output logic [NPINS-1:0] dly1_q,
    output logic [NPINS-1:0] dly2_q,
    output logic [NPINS-1:0] odrn_q,
    output logic [NPINS-1:0] rben_q,
    output logic [NPINS-1:0] evt
);
    localparam int HALF = DW / 2;

    logic             wr_dout, wr_set, wr_clr, wr_tgl, wr_sc;
    logic [NPINS-1:0] lo_bits, hi_bits;
    logic [NPINS-1:0] set_b, clr_b, tgl_b, dwr_b, out_d;

    // Decode the write strobes for the output data words
    always_comb begin
        wr_dout = wen && (addr == GP_DOUT);
        wr_set  = wen && (addr == GP_SET);
        wr_clr  = wen && (addr == GP_CLR);
        wr_tgl  = wen && (addr == GP_TGL);
        wr_sc   = wen && (addr == GP_SETCLR);
        lo_bits = wdata[NPINS-1:0];
        hi_bits = wdata[HALF +: NPINS];
        set_b   = (wr_set ? lo_bits : '0) | (wr_sc ? lo_bits : '0);
        clr_b   = (wr_clr ? lo_bits : '0) | (wr_sc ? hi_bits : '0);
        tgl_b   = wr_tgl ? lo_bits : '0;
        dwr_b   = wr_dout ? mask_q : '0;
        evt     = set_b | clr_b | tgl_b;
    end

    // Next output data per bit, set first, then clear, toggle, masked write
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (set_b[i])      out_d[i] = 1'b1;
            else if (clr_b[i]) out_d[i] = 1'b0;
            else if (tgl_b[i]) out_d[i] = ~out_q[i];
            else if (dwr_b[i]) out_d[i] = lo_bits[i];
            else               out_d[i] = out_q[i];
        end
    end

    // Output data register
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // Plain read/write control words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            mask_q  <= '1;
            pen_q   <= '0;
            pbase_q <= '0;
            dly1_q  <= '0;
            dly2_q  <= '0;
            odrn_q  <= '0;
            rben_q  <= '0;
        end else if (wen) begin
            case (addr)
                GP_DIR:   dir_q   <= lo_bits;
                GP_MASK:  mask_q  <= lo_bits;
                GP_PEN:   pen_q   <= lo_bits;
                GP_PBASE: pbase_q <= lo_bits;
                GP_DLY1:  dly1_q  <= lo_bits;
                GP_DLY2:  dly2_q  <= lo_bits;
                GP_ODRN:  odrn_q  <= lo_bits;
                GP_RBEN:  rben_q  <= lo_bits;
                default:  ;
            endcase
        end
    end

    // R1
    reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '1 && dir_q == '0 && out_q == '0));
    // R2
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(lo_bits)) == $past(lo_bits)));
    // R3
    setclr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> (((out_q & $past(lo_bits)) == $past(lo_bits)) &&
                   ((out_q & $past(hi_bits & ~lo_bits)) == '0)));
    // R5
    masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dout |=> (((out_q ^ $past(out_q)) & ~$past(mask_q)) == '0));
endmodule

// File: rtl/gpio_pin_drive.sv
// Module: gpio_pin_drive
// Output path of one pin: pulse generator, a three-stage delay line with a
// selectable tap, and push-pull or open-drain drive.
// Assumes evt is a one-cycle strobe from the register decode.
module gpio_pin_drive #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    input  logic out_bit,
    input  logic pen,
    input  logic pbase,
    input  logic evt,
    input  logic dly1,
    input  logic dly2,
    input  logic odrn,
    output logic pad_oe,
    output logic pad_out
);
    logic              pulse_q;
    logic              val;
    logic              val_d;
    logic [STAGES-1:0] pipe_q;

    // Pulse flag: high for the one cycle after an event on a pulse pin
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= evt & pen;
    end

    // Undelayed pin value
    always_comb val = pen ? (pulse_q ? ~pbase : pbase) : out_bit;

    // Delay line
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], val};
    end

    // Delay tap select and pad drive
    always_comb begin
        case ({dly2, dly1})
            2'b01:   val_d = pipe_q[0];
            2'b10:   val_d = pipe_q[1];
            2'b11:   val_d = pipe_q[2];
            default: val_d = val;
        endcase
        pad_out = val_d & ~odrn;
        pad_oe  = dir & ~(odrn & val_d);
    end

    // R8
    pulse_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pen && $past(pen) && !$past(evt) && !odrn && !dly1 && !dly2) |-> (pad_out == pbase));
    // R8
    pulse_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pen && $past(pen) && $past(evt) && !odrn && !dly1 && !dly2) |-> (pad_out == !pbase));
    // R9
    delay_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly1 && !dly2 && $past(dly1 && !dly2) && !pen && $past(!pen) && !odrn)
        |-> (pad_out == $past(out_bit)));
    // R10
    open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odrn && dir && !pen && !dly1 && !dly2) |-> (pad_oe == !out_bit && !pad_out));
endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs (top)
// GPIO port register unit: control registers, per-pin output drive and the
// raw and masked input read words on a simple synchronous register bus.
// Assumes pad_in is already synchronized to clk.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wen,
    input  logic [GP_AW-1:0] bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out
);
    logic [NPINS-1:0] dir_w, mask_w, out_w, pen_w, pbase_w;
    logic [NPINS-1:0] dly1_w, dly2_w, odrn_w, rben_w, evt_w;
    logic [NPINS-1:0] in_vis, in_msk;

    gpio_cfg_regs #(.NPINS(NPINS), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
        .dir_q(dir_w), .mask_q(mask_w), .out_q(out_w), .pen_q(pen_w), .pbase_q(pbase_w),
        .dly1_q(dly1_w), .dly2_q(dly2_w), .odrn_q(odrn_w), .rben_q(rben_w), .evt(evt_w)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_drive #(.STAGES(3)) drv_i (
            .clk(clk), .rst_n(rst_n), .dir(dir_w[p]), .out_bit(out_w[p]),
            .pen(pen_w[p]), .pbase(pbase_w[p]), .evt(evt_w[p]),
            .dly1(dly1_w[p]), .dly2(dly2_w[p]), .odrn(odrn_w[p]),
            .pad_oe(pad_oe[p]), .pad_out(pad_out[p])
        );
    end

    // Input visibility: inputs always, outputs only with readback enabled
    always_comb begin
        in_vis = pad_in & (~dir_w | rben_w);
        in_msk = in_vis & mask_w;
    end

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            GP_DOUT:  bus_rdata[NPINS-1:0] = out_w;
            GP_DIR:   bus_rdata[NPINS-1:0] = dir_w;
            GP_MASK:  bus_rdata[NPINS-1:0] = mask_w;
            GP_RAWIN: bus_rdata[NPINS-1:0] = in_vis;
            GP_MSKIN: bus_rdata[NPINS-1:0] = in_msk;
            GP_PEN:   bus_rdata[NPINS-1:0] = pen_w;
            GP_PBASE: bus_rdata[NPINS-1:0] = pbase_w;
            GP_DLY1:  bus_rdata[NPINS-1:0] = dly1_w;
            GP_DLY2:  bus_rdata[NPINS-1:0] = dly2_w;
            GP_ODRN:  bus_rdata[NPINS-1:0] = odrn_w;
            GP_RBEN:  bus_rdata[NPINS-1:0] = rben_w;
            default:  bus_rdata = '0;
        endcase
    end

    // R4
    push_pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_w == '0 && dly1_w == '0 && dly2_w == '0 && odrn_w == '0)
        |-> (pad_oe == dir_w && pad_out == out_w));
endmodule

// File: tb/gpio_port_regs_tb_top.sv
// Directed bench for gpio_port_regs: one task per scenario.
module gpio_port_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe, pad_out;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after the capturing edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd5, v);  check("R1 dir", v, 32'h0);
        rd(4'd6, v);  check("R1 mask", v, 32'h0000FFFF);
        rd(4'd0, v);  check("R1 dout", v, 32'h0);
        rd(4'd9, v);  check("R1 pen", v, 32'h0);
        rd(4'd11, v); check("R1 dly1", v, 32'h0);
        rd(4'd13, v); check("R1 odrn", v, 32'h0);
        check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    endtask

    task automatic t_set_clr_tgl;
        logic [31:0] v;
        wr(4'd1, 32'h0011); rd(4'd0, v); check("R2 set", v, 32'h0011);
        wr(4'd2, 32'h0001); rd(4'd0, v); check("R2 clear", v, 32'h0010);
        wr(4'd3, 32'h0110); rd(4'd0, v); check("R2 toggle", v, 32'h0100);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        wr(4'd1, 32'h0C00); rd(4'd0, v); check("R3 pre", v, 32'h0D00);
        wr(4'd4, 32'h0F00_0300); rd(4'd0, v); check("R3 set wins", v, 32'h0300);
    endtask

    task automatic t_dir;
        wr(4'd5, 32'h00F0);
        wr(4'd1, 32'h0050);
        check("R4 pad_oe", {16'h0, pad_oe}, 32'h00F0);
        check("R4 pad_out", {16'h0, pad_out}, 32'h0350);
    endtask

    task automatic t_masked_write;
        logic [31:0] v;
        wr(4'd2, 32'hFFFF);
        wr(4'd6, 32'h0F0F);
        wr(4'd0, 32'hFFFF); rd(4'd0, v); check("R5 masked write", v, 32'h0F0F);
        wr(4'd2, 32'hFFFF); rd(4'd0, v); check("R2 clear ignores mask", v, 32'h0);
        wr(4'd6, 32'hFFFF);
    endtask

    task automatic t_inputs;
        logic [31:0] v;
        wr(4'd5, 32'h0000);
        pad_in = 16'hA5A5;
        rd(4'd7, v); check("R6 raw", v, 32'hA5A5);
        wr(4'd6, 32'h00FF);
        rd(4'd8, v); check("R6 masked in", v, 32'h00A5);
        rd(4'd7, v); check("R6 raw ignores mask", v, 32'hA5A5);
        wr(4'd6, 32'hFFFF);
        wr(4'd5, 32'h0001);
        rd(4'd7, v); check("R7 output hidden", v, 32'hA5A4);
        wr(4'd14, 32'h0001);
        rd(4'd7, v); check("R7 readback", v, 32'hA5A5);
        wr(4'd14, 32'h0000);
        pad_in = 16'h0;
    endtask

    task automatic t_pulse;
        wr(4'd5, 32'h0018);
        wr(4'd10, 32'h0010);
        wr(4'd9, 32'h0018);
        check("R8 base rest", {31'h0, pad_out[4]}, 32'h1);
        wr(4'd1, 32'h0008);
        check("R8 pulse high", {31'h0, pad_out[3]}, 32'h1);
        @(negedge clk);
        check("R8 pulse back", {31'h0, pad_out[3]}, 32'h0);
        @(negedge clk);
        check("R8 pulse stays", {31'h0, pad_out[3]}, 32'h0);
        wr(4'd3, 32'h0010);
        check("R8 pulse low", {31'h0, pad_out[4]}, 32'h0);
        @(negedge clk);
        check("R8 pulse base", {31'h0, pad_out[4]}, 32'h1);
        wr(4'd9, 32'h0000);
        wr(4'd10, 32'h0000);
    endtask

    task automatic t_delay;
        wr(4'd2, 32'hFFFF);
        wr(4'd5, 32'h00E1);
        wr(4'd11, 32'h00A0);
        wr(4'd12, 32'h00C0);
        repeat (4) @(negedge clk);
        wr(4'd1, 32'h00E1);
        check("R9 no delay", {31'h0, pad_out[0]}, 32'h1);
        check("R9 edge0", {29'h0, pad_out[7:5]}, 32'h0);
        @(negedge clk);
        check("R9 one cycle", {29'h0, pad_out[7:5]}, 32'h1);
        @(negedge clk);
        check("R9 two cycles", {29'h0, pad_out[7:5]}, 32'h3);
        @(negedge clk);
        check("R9 three cycles", {29'h0, pad_out[7:5]}, 32'h7);
        wr(4'd11, 32'h0);
        wr(4'd12, 32'h0);
    endtask

    task automatic t_open_drain;
        wr(4'd5, 32'h0300);
        wr(4'd13, 32'h0100);
        wr(4'd2, 32'hFFFF);
        wr(4'd1, 32'h0200);
        check("R10 drive low oe", {30'h0, pad_oe[9:8]}, 32'h3);
        check("R10 drive low out", {30'h0, pad_out[9:8]}, 32'h2);
        wr(4'd1, 32'h0100);
        check("R10 release oe", {30'h0, pad_oe[9:8]}, 32'h2);
        check("R10 release out", {30'h0, pad_out[9:8]}, 32'h2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clr_tgl();
        t_setclr();
        t_dir();
        t_masked_write();
        t_inputs();
        t_pulse();
        t_delay();
        t_open_drain();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule